// File: doc/BRIEF.md
# Watchdog Early Warning Interrupt Unit

This unit sits next to a 12-bit down-counting independent watchdog. It holds a programmable early-warning threshold and an enable bit. When the watchdog count has fallen to the threshold or below, it raises a sticky interrupt flag. Software configures the unit through a simple write port, acknowledges the interrupt with a write-one strobe and reads the configuration back through plain read outputs.

Configuration writes are guarded three ways. The watchdog key logic must unlock them. No earlier update may still be in flight. The threshold must be a legal value, greater than 1. An accepted write travels to the compare logic over a fixed three-cycle transfer, during which a busy flag is high. The read-back values are the ones the compare logic is actually using, so they are trustworthy only while busy is low.

Top module: `wdg_ewi`

## Requirements
- R1: After reset, rd_thresh_o is 0, rd_enable_o is 0, busy_o is 0 and irq_o is 0.
- R2: On a cycle with cnt_tick_i high, active enable 1 and cnt_i <= active threshold, the flag sets, and irq_o is high from the following cycle.
- R3: irq_o is low whenever the active enable is 0. Once the enable is turned off, the flag is cleared.
- R4: A write with wr_en_i=1 and wr_ack_i=1 clears the flag, and irq_o is low the cycle after. This works whatever the state of unlock_i and busy_o. A write with wr_ack_i=0 leaves the flag as it is.
- R5: The flag is sticky. It stays set on later ticks that do not meet the condition. After an acknowledge, it sets again on the next tick that meets the condition.
- R6: A write is accepted when wr_en_i=1, unlock_i=1, busy_o=0 and wr_thresh_i>1. An accepted write drives busy_o high for exactly 3 cycles after the write edge. The new threshold and enable appear on rd_thresh_o/rd_enable_o, and in the compare logic, in the cycle busy_o falls.
- R7: Configuration writes made while busy_o=1 are ignored.
- R8: Configuration writes made while unlock_i=0 are ignored and do not raise busy_o.
- R9: A write with wr_thresh_i of 0 or 1 is rejected in full, enable included. The stored values are unchanged and busy_o stays low.
- R10: rd_thresh_o and rd_enable_o change only on the edge at which busy_o falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Watchdog-domain clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_thresh_i | input | 12 | Threshold write data |
| wr_enable_i | input | 1 | Enable write data |
| wr_ack_i | input | 1 | Acknowledge bit of the write (1 clears the flag) |
| unlock_i | input | 1 | Write unlock from the watchdog key logic |
| cnt_i | input | 12 | Live watchdog down-count |
| cnt_tick_i | input | 1 | Count-update strobe |
| rd_thresh_o | output | 12 | Active threshold read-back |
| rd_enable_o | output | 1 | Active enable read-back |
| busy_o | output | 1 | Configuration transfer in progress |
| irq_o | output | 1 | Early warning interrupt |

## Verification
busy_o rises in the cycle right after the write edge and stays high for three sampled cycles. The new configuration and the busy fall both appear on the third edge after the write. irq_o follows the qualifying tick or the acknowledge by one edge. The bench drives on the falling edge and samples 1 ns after each rising edge. At every sample it compares all outputs with a cycle model built from the requirements, which advances exactly one edge per call. Directed checks count these same edges before they compare against fixed expected values.

// File: rtl/wdg_ewi_pkg.sv
package wdg_ewi_pkg;
  localparam int CNT_W = 12;
  localparam int MIN_THRESH = 2;
  typedef logic [CNT_W-1:0] cnt_t;
  typedef struct packed {
    cnt_t thresh;
    logic en;
  } cfg_t;
endpackage

// File: rtl/wdg_ewi_regif.sv
module wdg_ewi_regif
  import wdg_ewi_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wr_en_i,
  input  cnt_t wr_thresh_i,
  input  logic wr_enable_i,
  input  logic wr_ack_i,
  input  logic unlock_i,
  input  logic busy_i,
  output logic accept_o,
  output logic ack_o,
  output cfg_t pend_o
);
  logic thresh_ok;

  assign thresh_ok = wr_thresh_i >= cnt_t'(MIN_THRESH);
  assign accept_o  = wr_en_i && unlock_i && !busy_i && thresh_ok;
  // acknowledge is not write-protected
  assign ack_o     = wr_en_i && wr_ack_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_o <= '0;
    end else if (accept_o) begin
      pend_o.thresh <= wr_thresh_i;
      pend_o.en     <= wr_enable_i;
    end
  end
endmodule

// File: rtl/wdg_ewi_xfer.sv
module wdg_ewi_xfer
  import wdg_ewi_pkg::*;
#(
  parameter int LAT = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic accept_i,
  input  cfg_t pend_i,
  output logic busy_o,
  output cfg_t active_o
);
  logic [LAT-1:0] stage_q;

  generate
    if (LAT == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q <= '0;
        else         stage_q <= accept_i;
      end
    end else begin : g_shift
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q <= '0;
        else         stage_q <= {stage_q[LAT-2:0], accept_i};
      end
    end
  endgenerate

  assign busy_o = |stage_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              active_o <= '0;
    else if (stage_q[LAT-1])  active_o <= pend_i;
  end
endmodule

// File: rtl/wdg_ewi_cmp.sv
module wdg_ewi_cmp
  import wdg_ewi_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  cnt_t cnt_i,
  input  logic tick_i,
  input  logic ack_i,
  input  cfg_t active_i,
  output logic irq_o
);
  logic flag_q, hit;

  assign hit = tick_i && active_i.en && (cnt_i <= active_i.thresh);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             flag_q <= 1'b0;
    else if (!active_i.en)   flag_q <= 1'b0;
    else if (ack_i)          flag_q <= 1'b0;
    else if (hit)            flag_q <= 1'b1;
  end

  assign irq_o = flag_q && active_i.en;
endmodule

// File: rtl/wdg_ewi.sv
module wdg_ewi
  import wdg_ewi_pkg::*;
#(
  parameter int XFER_LAT = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [CNT_W-1:0] wr_thresh_i,
  input  logic             wr_enable_i,
  input  logic             wr_ack_i,
  input  logic             unlock_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             cnt_tick_i,
  output logic [CNT_W-1:0] rd_thresh_o,
  output logic             rd_enable_o,
  output logic             busy_o,
  output logic             irq_o
);
  logic accept, ack;
  cfg_t pend, active;

  wdg_ewi_regif u_regif (
    .clk_i, .rst_ni, .wr_en_i, .wr_thresh_i, .wr_enable_i, .wr_ack_i,
    .unlock_i, .busy_i(busy_o), .accept_o(accept), .ack_o(ack), .pend_o(pend)
  );

  wdg_ewi_xfer #(.LAT(XFER_LAT)) u_xfer (
    .clk_i, .rst_ni, .accept_i(accept), .pend_i(pend),
    .busy_o, .active_o(active)
  );

  wdg_ewi_cmp u_cmp (
    .clk_i, .rst_ni, .cnt_i, .tick_i(cnt_tick_i), .ack_i(ack),
    .active_i(active), .irq_o
  );

  assign rd_thresh_o = active.thresh;
  assign rd_enable_o = active.en;
endmodule

// File: rtl/wdg_ewi_chk.sv
module wdg_ewi_chk
  import wdg_ewi_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             wr_en_i,
  input logic             wr_ack_i,
  input logic [CNT_W-1:0] cnt_i,
  input logic             cnt_tick_i,
  input logic [CNT_W-1:0] rd_thresh_o,
  input logic             rd_enable_o,
  input logic             busy_o,
  input logic             irq_o
);
  a_r2_irq_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(cnt_tick_i && (cnt_i <= rd_thresh_o)));

  a_r4_ack_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_ack_i) |=> !irq_o);

  a_r6_busy_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |=> busy_o);

  a_r10_cfg_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |=> ($stable(rd_thresh_o) && $stable(rd_enable_o)));

  a_r9_thresh_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(rd_thresh_o) |-> (rd_thresh_o > 1));
endmodule

bind wdg_ewi wdg_ewi_chk u_chk (
  .clk_i, .rst_ni, .wr_en_i, .wr_ack_i, .cnt_i, .cnt_tick_i,
  .rd_thresh_o, .rd_enable_o, .busy_o, .irq_o
);

// File: tb/wdg_ewi_tb.sv
module wdg_ewi_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 0, wr_enable = 0, wr_ack = 0, unlock = 0, tick = 0;
  logic [11:0] wr_thresh = 0, cnt = 12'hfff;
  logic [11:0] rd_thresh;
  logic rd_enable, busy, irq;
  int total = 0, bad = 0;
  bit done = 0;

  // reference model state
  logic [11:0] m_th = 0, m_pth = 0;
  logic m_en = 0, m_pen = 0, m_flag = 0;
  int m_cnt = 0;

  always #5 clk = ~clk;

  wdg_ewi u_dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_thresh_i(wr_thresh),
    .wr_enable_i(wr_enable), .wr_ack_i(wr_ack), .unlock_i(unlock),
    .cnt_i(cnt), .cnt_tick_i(tick), .rd_thresh_o(rd_thresh),
    .rd_enable_o(rd_enable), .busy_o(busy), .irq_o(irq)
  );

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit accepts(logic w, logic u, int mc, logic [11:0] th);
    return w && u && (mc == 0) && (th > 1);
  endfunction

  task automatic model_step();
    logic acc;
    logic nflag;
    acc = accepts(wr_en, unlock, m_cnt, wr_thresh);
    nflag = m_flag;
    if (!m_en) nflag = 0;
    else if (wr_en && wr_ack) nflag = 0;
    else if (tick && cnt <= m_th) nflag = 1;
    m_flag = nflag;
    if (acc) begin
      m_cnt = 3; m_pth = wr_thresh; m_pen = wr_enable;
    end else if (m_cnt > 0) begin
      m_cnt--;
      if (m_cnt == 0) begin m_th = m_pth; m_en = m_pen; end
    end
  endtask

  task automatic cyc(logic w, logic [11:0] th, logic en, logic a, logic u,
                     logic [11:0] c, logic t);
    @(negedge clk);
    wr_en = w; wr_thresh = th; wr_enable = en; wr_ack = a; unlock = u;
    cnt = c; tick = t;
    @(posedge clk);
    #1;
    model_step();
    chk("R6 busy", busy, int'(m_cnt != 0));
    chk("R10 thresh", rd_thresh, m_th);
    chk("R10 enable", rd_enable, m_en);
    chk("R2 irq", irq, int'(m_flag && m_en));
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0, 12'hfff, 0);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    #23 rst_n = 1'b1;
    #1;
    // R1 reset state
    chk("R1 thresh", rd_thresh, 0);
    chk("R1 enable", rd_enable, 0);
    chk("R1 busy", busy, 0);
    chk("R1 irq", irq, 0);

    // R6 accepted write, 3 busy cycles
    cyc(1, 100, 1, 0, 1, 12'hfff, 0);
    chk("R6 busy after write", busy, 1);
    idle(2);
    chk("R6 busy still high", busy, 1);
    chk("R6 thresh not yet", rd_thresh, 0);
    idle(1);
    chk("R6 busy low", busy, 0);
    chk("R6 thresh applied", rd_thresh, 100);

    // R2 threshold compare
    cyc(0, 0, 0, 0, 0, 101, 1);
    chk("R2 above threshold", irq, 0);
    cyc(0, 0, 0, 0, 0, 100, 1);
    chk("R2 equal threshold", irq, 1);
    // R5 sticky
    cyc(0, 0, 0, 0, 0, 500, 1);
    chk("R5 sticky", irq, 1);
    // R4 ack=0 no effect, ack=1 clears while locked
    cyc(1, 0, 0, 0, 0, 99, 0);
    chk("R4 ack zero", irq, 1);
    cyc(1, 0, 0, 1, 0, 99, 0);
    chk("R4 ack clears", irq, 0);
    cyc(0, 0, 0, 0, 0, 90, 1);
    chk("R5 sets again", irq, 1);

    // R8 locked write ignored
    cyc(1, 200, 0, 0, 0, 12'hfff, 0);
    chk("R8 no busy", busy, 0);
    idle(4);
    chk("R8 thresh kept", rd_thresh, 100);
    // R9 illegal threshold
    cyc(1, 1, 0, 0, 1, 12'hfff, 0);
    chk("R9 no busy", busy, 0);
    cyc(1, 0, 0, 0, 1, 12'hfff, 0);
    idle(4);
    chk("R9 thresh kept", rd_thresh, 100);
    chk("R9 enable kept", rd_enable, 1);

    // R7 write during busy ignored
    cyc(1, 300, 1, 0, 1, 12'hfff, 0);
    cyc(1, 400, 0, 0, 1, 12'hfff, 0);
    idle(3);
    chk("R7 thresh", rd_thresh, 300);
    chk("R7 enable", rd_enable, 1);

    // R3 disable clears interrupt
    cyc(0, 0, 0, 0, 0, 5, 1);
    chk("R3 irq before disable", irq, 1);
    cyc(1, 300, 0, 0, 1, 12'hfff, 0);
    idle(3);
    chk("R3 irq off", irq, 0);
    cyc(0, 0, 0, 0, 0, 5, 1);
    chk("R3 disabled no irq", irq, 0);

    // random phase
    for (int i = 0; i < 4000; i++) begin
      logic w, u, a, t, e;
      logic [11:0] th, c;
      w  = ($urandom % 6) == 0;
      u  = ($urandom % 10) < 7;
      a  = ($urandom % 8) == 0;
      t  = ($urandom % 2) == 0;
      e  = ($urandom % 4) != 0;
      th = ($urandom % 8 == 0) ? 12'($urandom % 3) : 12'($urandom % 4096);
      c  = 12'($urandom % 4096);
      cyc(w, th, e, a, u, c, t);
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule